// File: doc/BRIEF.md
# Legacy Level Interrupt Merger

This block gathers level-style legacy interrupt events arriving from a number of downstream serial-link ports and folds them into four virtual interrupt lines, lettered A to D. Every inbound event carries a raise or drop indication, the letter it concerns and the index of the port it came from. For each port and each letter the block holds one tracking bit. A virtual line is high whenever any port has its bit set for that letter.

Upstream traffic is produced only when a virtual line changes level. A raise message goes out when a line moves from low to high. A drop message goes out once every port has released that letter. Upstream therefore never sees more than four interrupts in flight, whatever the number of downstream sources. Because the output is again a stream of raise and drop events per letter, one instance can drive the inbound side of another instance higher up a hierarchy.

Messages leave over a valid/ready handshake. Each letter keeps a record of the level it last reported. A letter is pending while its line differs from that record. When several letters are pending, the lowest letter code is offered first.

Top module: `intx_aggregator`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all tracking bits and all records of the last level reported. After reset, wire_state is 0 and up_valid is 0.
- R2: An inbound event with in_valid=1 and in_assert=1 sets the tracking bit for (in_port, in_letter). The matching wire_state bit is high from the next clock edge onward. Letters are coded A=0, B=1, C=2, D=3, and wire_state bit k carries letter k.
- R3: wire_state bit k is the OR of letter k's tracking bits over all ports. A drop from one port leaves the line high while any other port still holds that letter.
- R4: A drop event (in_assert=0) for a bit that is already clear changes nothing. An event whose in_port is NUM_PORTS or above changes nothing. Neither event produces upstream traffic.
- R5: A raise message goes upstream only after a letter's line goes from 0 to 1. A repeated raise for a letter already reported high produces no message.
- R6: A drop message for a letter goes upstream only when that letter's tracking bits are clear on every port.
- R7: An upstream message is carried by up_valid, up_assert (1 = raise, 0 = drop) and up_letter (the letter code). While up_ready is 0 and the line is unchanged, the offer stays valid with the same content. It is consumed on a cycle with up_valid and up_ready both 1.
- R8: When several letters are pending, the lowest letter code is offered first, one letter per accepted handshake.
- R9: If a line changes and then returns to its last reported level before a message is accepted, the letter stops being pending and no message is sent for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Inbound event present this cycle |
| in_assert | input | 1 | 1 = raise, 0 = drop |
| in_letter | input | 2 | Letter code, A=0 to D=3 |
| in_port | input | PORT_W | Index of the downstream port that sent the event |
| up_valid | output | 1 | Upstream message offered |
| up_ready | input | 1 | Upstream side accepts the offer this cycle |
| up_assert | output | 1 | Upstream message type, 1 = raise, 0 = drop |
| up_letter | output | 2 | Upstream message letter code |
| wire_state | output | 4 | Current level of the four virtual lines |

## Verification
The bench targets shared letters, where one port drops while another still holds the letter. A design that ORs wrongly would drop the line early and send a false drop. It also targets repeated raises and drops of clear bits, which a design that sends on every event rather than on line edges would turn into duplicate messages. Out-of-range port indices are driven as well; a design that decodes them with truncation would corrupt a real port's bit. Priority among several pending letters, a stalled handshake, and a line that returns to its reported level before acceptance are all exercised, and a long pseudo-random sweep with a reference model compares every output on every cycle.

// File: rtl/intx_agg_pkg.sv
package intx_agg_pkg;
  localparam int LETTERS = 4;
  localparam int LW      = 2;

  typedef enum logic [LW-1:0] {LTR_A = 2'd0, LTR_B = 2'd1, LTR_C = 2'd2, LTR_D = 2'd3} letter_e;

  // lowest set index of a letter vector (0 when empty)
  function automatic logic [LW-1:0] first_set(input logic [LETTERS-1:0] v);
    logic [LW-1:0] idx;
    idx = '0;
    for (int k = LETTERS - 1; k >= 0; k--) begin
      if (v[k]) idx = LW'(k);
    end
    return idx;
  endfunction

  // mask of all letters with a lower code than idx
  function automatic logic [LETTERS-1:0] below_mask(input logic [LW-1:0] idx);
    logic [LETTERS-1:0] m;
    for (int k = 0; k < LETTERS; k++) m[k] = (LW'(k) < idx);
    return m;
  endfunction

  // one-hot decode of a letter code
  function automatic logic [LETTERS-1:0] letter_hot(input logic [LW-1:0] idx);
    logic [LETTERS-1:0] m;
    for (int k = 0; k < LETTERS; k++) m[k] = (LW'(k) == idx);
    return m;
  endfunction
endpackage

// File: rtl/intx_track.sv
module intx_track
  import intx_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic               ev_assert,
  input  logic [LW-1:0]      ev_letter,
  input  logic [PORT_W-1:0]  ev_port,
  output logic [LETTERS-1:0] vwire,
  output logic               ev_hit
);
  logic [LETTERS-1:0] trk [NUM_PORTS];
  logic [NUM_PORTS-1:0] port_sel;
  logic [LETTERS-1:0] ltr_sel;

  assign ltr_sel = letter_hot(ev_letter);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_sel[p] = ev_valid && ({1'b0, ev_port} == (PORT_W + 1)'(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        trk[p] <= '0;
      end else if (port_sel[p]) begin
        for (int k = 0; k < LETTERS; k++) begin
          if (ltr_sel[k]) trk[p][k] <= ev_assert;
        end
      end
    end
  end

  assign ev_hit = |port_sel;

  always_comb begin
    vwire = '0;
    for (int p = 0; p < NUM_PORTS; p++) vwire = vwire | trk[p];
  end
endmodule

// File: rtl/intx_pending.sv
module intx_pending
  import intx_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [LETTERS-1:0] vwire,
  input  logic               acc,
  input  logic [LW-1:0]      acc_letter,
  input  logic               acc_type,
  output logic [LETTERS-1:0] pend,
  output logic [LETTERS-1:0] sent
);
  logic [LETTERS-1:0] acc_hot;
  assign acc_hot = letter_hot(acc_letter);

  for (genvar k = 0; k < LETTERS; k++) begin : g_ltr
    always_ff @(posedge clk) begin
      if (rst) begin
        sent[k] <= 1'b0;
      end else if (acc && acc_hot[k]) begin
        sent[k] <= acc_type;
      end
    end
    assign pend[k] = vwire[k] ^ sent[k];
  end
endmodule

// File: rtl/intx_arbiter.sv
module intx_arbiter
  import intx_agg_pkg::*;
(
  input  logic [LETTERS-1:0] pend,
  input  logic [LETTERS-1:0] vwire,
  output logic               offer,
  output logic [LW-1:0]      pick,
  output logic               pick_type,
  output logic [LETTERS-1:0] grant
);
  assign offer     = |pend;
  assign pick      = first_set(pend);
  assign pick_type = vwire[pick];
  assign grant     = offer ? letter_hot(pick) : '0;
endmodule

// File: rtl/intx_aggregator.sv
module intx_aggregator
  import intx_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_assert,
  input  logic [1:0]        in_letter,
  input  logic [PORT_W-1:0] in_port,
  output logic              up_valid,
  input  logic              up_ready,
  output logic              up_assert,
  output logic [1:0]        up_letter,
  output logic [3:0]        wire_state
);
  logic [LETTERS-1:0] vwire;
  logic [LETTERS-1:0] pend_vec;
  logic [LETTERS-1:0] sent_vec;
  logic [LETTERS-1:0] grant_vec;
  logic               ev_hit;
  logic               handshake;
  logic               offer;
  logic [LW-1:0]      pick;
  logic               pick_type;

  intx_track #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (in_valid),
    .ev_assert (in_assert),
    .ev_letter (in_letter),
    .ev_port   (in_port),
    .vwire     (vwire),
    .ev_hit    (ev_hit)
  );

  intx_pending u_pend (
    .clk        (clk),
    .rst        (rst),
    .vwire      (vwire),
    .acc        (handshake),
    .acc_letter (pick),
    .acc_type   (pick_type),
    .pend       (pend_vec),
    .sent       (sent_vec)
  );

  intx_arbiter u_arb (
    .pend      (pend_vec),
    .vwire     (vwire),
    .offer     (offer),
    .pick      (pick),
    .pick_type (pick_type),
    .grant     (grant_vec)
  );

  assign handshake  = offer && up_ready;
  assign up_valid   = offer;
  assign up_letter  = pick;
  assign up_assert  = pick_type;
  assign wire_state = vwire;
endmodule

// File: rtl/intx_aggregator_chk.sv
module intx_aggregator_chk
  import intx_agg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_assert,
  input logic [1:0]        in_letter,
  input logic [PORT_W-1:0] in_port,
  input logic              up_valid,
  input logic              up_ready,
  input logic              up_assert,
  input logic [1:0]        up_letter,
  input logic [3:0]        wire_state,
  input logic [3:0]        pend_vec,
  input logic [3:0]        grant_vec
);
  logic [3:0] shadow;
  logic       in_ok;

  assign in_ok = {1'b0, in_port} < (PORT_W + 1)'(NUM_PORTS);

  always_ff @(posedge clk) begin
    if (rst) shadow <= '0;
    else if (up_valid && up_ready) shadow[up_letter] <= up_assert;
  end

  // R1
  reset_clean_chk: assert property (@(posedge clk) rst |=> (wire_state == 4'd0 && !up_valid));

  // R2
  raise_sets_wire_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_assert && in_ok) |=> wire_state[$past(in_letter)]);

  // R5
  no_repeat_msg_chk: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> (up_assert != shadow[up_letter]));

  // R5
  raise_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_assert) |-> wire_state[up_letter]);

  // R6
  drop_needs_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_assert) |-> !wire_state[up_letter]);

  // R7
  offer_held_chk: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_ready) |=> (up_valid || (wire_state != $past(wire_state))));

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    up_valid |-> ((pend_vec & below_mask(up_letter)) == 4'd0));

  // R8
  single_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec) && (up_valid == ($countones(grant_vec) == 1)));
endmodule

bind intx_aggregator intx_aggregator_chk #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_assert  (in_assert),
  .in_letter  (in_letter),
  .in_port    (in_port),
  .up_valid   (up_valid),
  .up_ready   (up_ready),
  .up_assert  (up_assert),
  .up_letter  (up_letter),
  .wire_state (wire_state),
  .pend_vec   (pend_vec),
  .grant_vec  (grant_vec)
);

// File: tb/intx_aggregator_test.sv
module intx_aggregator_test;
  localparam int NP = 3;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_assert = 1'b0;
  logic [1:0] in_letter = '0;
  logic [PW-1:0] in_port = '0;
  logic up_ready = 1'b0;
  logic up_valid, up_assert;
  logic [1:0] up_letter;
  logic [3:0] wire_state;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  bit [3:0] m_trk [4];
  bit [3:0] m_sent;

  always #5 clk = ~clk;

  intx_aggregator #(.NUM_PORTS(NP)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_assert(in_assert),
    .in_letter(in_letter), .in_port(in_port), .up_valid(up_valid),
    .up_ready(up_ready), .up_assert(up_assert), .up_letter(up_letter),
    .wire_state(wire_state)
  );

  function automatic bit [3:0] m_wire();
    bit [3:0] w = '0;
    for (int p = 0; p < NP; p++) w |= m_trk[p];
    return w;
  endfunction

  function automatic bit [3:0] m_pend();
    return m_wire() ^ m_sent;
  endfunction

  function automatic int m_pick();
    bit [3:0] pd = m_pend();
    for (int k = 0; k < 4; k++) if (pd[k]) return k;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_model(string tag);
    chk({tag, " wire_state"}, wire_state, m_wire());
    chk({tag, " up_valid"}, up_valid, (m_pend() != 0));
    if (m_pend() != 0) begin
      chk({tag, " up_letter"}, up_letter, m_pick());
      chk({tag, " up_assert"}, up_assert, m_wire()[m_pick()]);
    end
  endtask

  // drive one cycle; called at a negedge, returns at the next negedge
  task automatic step(bit v, bit a, int l, int p, bit r);
    bit [3:0] w;
    in_valid  = v;
    in_assert = a;
    in_letter = 2'(l);
    in_port   = PW'(p);
    up_ready  = r;
    w = m_wire();
    if ((m_pend() != 0) && r) m_sent[m_pick()] = w[m_pick()];
    if (v && p < NP) m_trk[p][l] = a;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(bit r);
    step(1'b0, 1'b0, 0, 0, r);
  endtask

  initial begin
    for (int p = 0; p < 4; p++) m_trk[p] = '0;
    m_sent = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 wire after reset", wire_state, 0);
    chk("R1 valid after reset", up_valid, 0);

    // R2 raise A from port 0, stalled
    step(1, 1, 0, 0, 0);
    chk("R2 wire A high", wire_state[0], 1);
    chk("R7 raise offered", up_valid, 1);
    chk("R7 letter A code 0", up_letter, 0);
    chk("R7 type raise=1", up_assert, 1);
    idle(0);
    chk("R7 offer held under stall", up_valid, 1);
    chk("R7 held letter", up_letter, 0);
    idle(1);
    chk("R7 consumed on handshake", up_valid, 0);

    // R3 / R5 shared letter
    step(1, 1, 0, 1, 1);
    chk("R5 repeat raise silent", up_valid, 0);
    step(1, 0, 0, 0, 1);
    chk("R3 line held by other port", wire_state[0], 1);
    chk("R6 no early drop", up_valid, 0);
    step(1, 0, 0, 0, 1);
    chk("R4 drop of clear bit ignored", up_valid, 0);
    chk("R4 line unchanged", wire_state, 4'b0001);
    step(1, 1, 1, 3, 1);
    chk("R4 out of range port ignored", wire_state, 4'b0001);
    chk("R4 out of range no message", up_valid, 0);
    step(1, 0, 0, 3, 1);
    chk("R4 out of range drop ignored", wire_state, 4'b0001);

    // R6 last holder drops
    step(1, 0, 0, 1, 0);
    chk("R6 line A low", wire_state[0], 0);
    chk("R6 drop offered", up_valid, 1);
    chk("R6 type drop=0", up_assert, 0);
    idle(1);
    chk("R6 drop consumed", up_valid, 0);

    // R8 priority
    step(1, 1, 3, 2, 0);
    step(1, 1, 2, 1, 0);
    step(1, 1, 1, 0, 0);
    chk("R8 B first", up_letter, 1);
    idle(1);
    chk("R8 then C", up_letter, 2);
    idle(1);
    chk("R8 then D", up_letter, 3);
    idle(1);
    chk("R8 all sent", up_valid, 0);

    // R9 return before send
    step(1, 1, 0, 2, 0);
    chk("R9 pending after raise", up_valid, 1);
    step(1, 0, 0, 2, 0);
    chk("R9 pending withdrawn", up_valid, 0);
    idle(1);
    chk("R9 nothing sent", up_valid, 0);
    compare_model("R9 model");

    // reset mid-traffic
    step(1, 1, 2, 0, 0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < 4; p++) m_trk[p] = '0;
    m_sent = '0;
    chk("R1 reset clears lines", wire_state, 0);
    chk("R1 reset clears pending", up_valid, 0);

    // near-exhaustive sweep against the reference model (R2..R9)
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[0] | lfsr[7], lfsr[1], int'(lfsr[3:2]), int'(lfsr[5:4]),
             lfsr[6] & lfsr[9]);
        compare_model("R7 sweep");
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule